// File: doc/BRIEF.md
# Pipelined Radix-4 Unsigned Multiplier

This block multiplies two unsigned operands and returns their full-width product. It works through the multiplier two bits at a time. Each pipeline stage reads the lowest two-bit digit of its own copy of the multiplier. That digit picks zero, one, two or three times the multiplicand, and the stage adds the pick, at the digit's weight, into a running sum. The multiplier copy passes to the next stage shifted right by two places. This shift is plain wiring: the two low bits are dropped and zeros enter at the top.

An entry register captures the operands, and one stage follows for each digit. With the default 16-bit operands there are eight digit stages, so every product appears a fixed 9 cycles after its operands were presented. A new operand pair may be offered on every cycle, and results leave in issue order. The block has no stall or backpressure. A parameter chooses whether the triple multiple is formed once at the entry and carried down the pipe, or formed again inside each stage.

Top module: `r4m_mult`

## Requirements
- R1: When `res_vld` is high, `res_prod` equals the unsigned product of the `op_a` and `op_b` values that were offered with `op_vld` high 9 cycles earlier.
- R2: A pair presented with `op_vld` high in cycle t produces `res_vld` high in cycle t+9, and in no other cycle.
- R3: Operand pairs may be offered on consecutive cycles without gaps. Every pair yields its own result, and results come out in the order the pairs were offered.
- R4: While `rst` is high at a clock edge, every in-flight operation is discarded. `res_vld` is low in the cycle after that edge and stays low until a pair offered after reset completes.
- R5: A cycle with `op_vld` low produces no result: `res_vld` is low exactly 9 cycles later.
- R6: The extreme operands are exact. 0xFFFF × 0xFFFF gives 0xFFFE0001, and any product with a zero operand gives 0.
- R7: Each two-bit multiplier digit is decoded as 00 → 0, 01 → M, 10 → 2M and 11 → 3M, where M is `op_a`. The selected multiple is added with weight 4^k for digit k, counted from the least significant end. This holds for multipliers whose digits are all the same and for a single non-zero digit at any position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all valid flags |
| op_vld | input | 1 | Operand pair on `op_a`/`op_b` is valid this cycle |
| op_a | input | 16 | Multiplicand, unsigned |
| op_b | input | 16 | Multiplier, unsigned |
| res_vld | output | 1 | `res_prod` carries a finished product |
| res_prod | output | 32 | Unsigned product |

## Verification
The bench goes after the digit decode. It uses multipliers made of one repeated digit, and a single non-zero digit walked across all eight positions. A swapped mux leg or a wrong stage weight then gives a visibly wrong product, instead of hiding inside a random sum. It drives 0xFFFF × 0xFFFF: a sum or a triple multiple that is one bit too narrow would lose the carry and return a truncated value. It also measures the latency of every result, and it mixes back-to-back issue with idle cycles, so a stage whose valid flag slips or sticks shows up as a missing, early, late or phantom result. Last, it resets the block with operations in flight and then watches for any result that should have been discarded.

// File: rtl/r4m_pkg.sv
package r4m_pkg;

   // Decode of one radix-4 multiplier digit
   typedef enum logic [1:0] {
      R4M_SEL_ZERO  = 2'b00,
      R4M_SEL_ONCE  = 2'b01,
      R4M_SEL_TWICE = 2'b10,
      R4M_SEL_THRICE = 2'b11
   } r4m_sel_e;

   function automatic int r4m_digit_count(input int opw);
      return opw / 2;
   endfunction

endpackage

// File: rtl/r4m_entry.sv
// Entry register: captures operands, optionally forms 3M once.
module r4m_entry #(
   parameter int OPW   = 16,
   parameter int PRE3M = 1,
   localparam int PW   = 2 * OPW,
   localparam int MW   = OPW + 2
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           vld_i,
   input  logic [OPW-1:0] a_i,
   input  logic [OPW-1:0] b_i,
   output logic           vld_q,
   output logic [OPW-1:0] m_q,
   output logic [MW-1:0]  m3_q,
   output logic [OPW-1:0] b_q,
   output logic [PW-1:0]  acc_q
);

   always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= vld_i;
   end

   always_ff @(posedge clk) begin
      m_q   <= a_i;
      b_q   <= b_i;
      acc_q <= '0;
   end

   generate
      if (PRE3M != 0) begin : g_m3_once
         always_ff @(posedge clk)
            m3_q <= {2'b00, a_i} + {1'b0, a_i, 1'b0};
      end else begin : g_m3_none
         assign m3_q = '0;
      end
   endgenerate

endmodule

// File: rtl/r4m_digit.sv
// One radix-4 digit stage: select multiple, accumulate, shift multiplier.
module r4m_digit
   import r4m_pkg::*;
#(
   parameter int OPW   = 16,
   parameter int IDX   = 0,
   parameter int PRE3M = 1,
   localparam int PW   = 2 * OPW,
   localparam int MW   = OPW + 2,
   localparam int SH   = 2 * IDX
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           vld_i,
   input  logic [OPW-1:0] m_i,
   input  logic [MW-1:0]  m3_i,
   input  logic [OPW-1:0] b_i,
   input  logic [PW-1:0]  acc_i,
   output logic           vld_q,
   output logic [OPW-1:0] m_q,
   output logic [MW-1:0]  m3_q,
   output logic [OPW-1:0] b_q,
   output logic [PW-1:0]  acc_q
);

   logic [MW-1:0] triple;
   logic [MW-1:0] pick;
   logic [PW-1:0] addend;
   r4m_sel_e      sel;

   generate
      if (PRE3M != 0) begin : g_m3_carried
         assign triple = m3_i;
      end else begin : g_m3_local
         logic unused_m3;
         assign unused_m3 = ^m3_i;
         assign triple = {2'b00, m_i} + {1'b0, m_i, 1'b0};
      end
   endgenerate

   assign sel = r4m_sel_e'(b_i[1:0]);

   always_comb begin
      unique case (sel)
         R4M_SEL_ZERO:   pick = '0;
         R4M_SEL_ONCE:   pick = {2'b00, m_i};
         R4M_SEL_TWICE:  pick = {1'b0, m_i, 1'b0};
         R4M_SEL_THRICE: pick = triple;
         default:        pick = '0;
      endcase
   end

   assign addend = PW'(pick) << SH;

   always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= vld_i;
   end

   always_ff @(posedge clk) begin
      m_q   <= m_i;
      m3_q  <= m3_i;
      b_q   <= {2'b00, b_i[OPW-1:2]};
      acc_q <= acc_i + addend;
   end

endmodule

// File: rtl/r4m_mult.sv
// Top: entry register followed by one stage per radix-4 digit.
module r4m_mult
   import r4m_pkg::*;
#(
   parameter int OPW   = 16,
   parameter int PRE3M = 1,
   localparam int PW   = 2 * OPW,
   localparam int MW   = OPW + 2,
   localparam int ND   = r4m_digit_count(OPW),
   localparam int LAT  = ND + 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           op_vld,
   input  logic [OPW-1:0] op_a,
   input  logic [OPW-1:0] op_b,
   output logic           res_vld,
   output logic [PW-1:0]  res_prod
);

   generate
      if (OPW < 2 || (OPW % 2) != 0) begin : g_bad_width
         $error("r4m_mult: OPW must be even and at least 2");
      end
      if (PRE3M != 0 && PRE3M != 1) begin : g_bad_pre3m
         $error("r4m_mult: PRE3M must be 0 or 1");
      end
   endgenerate

   logic           v_p   [0:ND];
   logic [OPW-1:0] m_p   [0:ND];
   logic [MW-1:0]  m3_p  [0:ND];
   logic [OPW-1:0] b_p   [0:ND];
   logic [PW-1:0]  acc_p [0:ND];

   r4m_entry #(.OPW(OPW), .PRE3M(PRE3M)) u_entry (
      .clk   (clk),
      .rst   (rst),
      .vld_i (op_vld),
      .a_i   (op_a),
      .b_i   (op_b),
      .vld_q (v_p[0]),
      .m_q   (m_p[0]),
      .m3_q  (m3_p[0]),
      .b_q   (b_p[0]),
      .acc_q (acc_p[0])
   );

   generate
      for (genvar k = 0; k < ND; k++) begin : g_stage
         r4m_digit #(.OPW(OPW), .IDX(k), .PRE3M(PRE3M)) u_digit (
            .clk   (clk),
            .rst   (rst),
            .vld_i (v_p[k]),
            .m_i   (m_p[k]),
            .m3_i  (m3_p[k]),
            .b_i   (b_p[k]),
            .acc_i (acc_p[k]),
            .vld_q (v_p[k+1]),
            .m_q   (m_p[k+1]),
            .m3_q  (m3_p[k+1]),
            .b_q   (b_p[k+1]),
            .acc_q (acc_p[k+1])
         );
      end
   endgenerate

   logic unused_tail;
   assign unused_tail = ^{m_p[ND], m3_p[ND], b_p[ND]};

   assign res_vld  = v_p[ND];
   assign res_prod = acc_p[ND];

endmodule

// File: rtl/r4m_mult_chk.sv
// Property checker bound to r4m_mult.
module r4m_mult_chk #(
   parameter int OPW = 16,
   parameter int LAT = 9,
   localparam int PW = 2 * OPW
) (
   input logic           clk,
   input logic           rst,
   input logic           op_vld,
   input logic [OPW-1:0] op_a,
   input logic [OPW-1:0] op_b,
   input logic           res_vld,
   input logic [PW-1:0]  res_prod
);

   localparam logic [PW-1:0] OPMAX = PW'({OPW{1'b1}});
   localparam logic [PW-1:0] PMAX  = OPMAX * OPMAX;

   logic [LAT-1:0] vh;
   logic [PW-1:0]  ph [LAT];

   always_ff @(posedge clk) begin
      if (rst) vh <= '0;
      else     vh <= {vh[LAT-2:0], op_vld};
   end

   always_ff @(posedge clk) begin
      ph[0] <= PW'(op_a) * PW'(op_b);
      for (int i = 1; i < LAT; i++) ph[i] <= ph[i-1];
   end

   AST_RESULT_VALUE: assert property (@(posedge clk) disable iff (rst)
      res_vld |-> (res_prod == ph[LAT-1])); // R1

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
      res_vld == vh[LAT-1]); // R2

   AST_BUBBLE_KEPT: assert property (@(posedge clk) disable iff (rst)
      !vh[LAT-1] |-> !res_vld); // R5

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> !res_vld); // R4

   AST_PROD_CEILING: assert property (@(posedge clk) disable iff (rst)
      res_vld |-> (res_prod <= PMAX)); // R6

endmodule

bind r4m_mult r4m_mult_chk #(.OPW(OPW), .LAT(LAT)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .op_vld   (op_vld),
   .op_a     (op_a),
   .op_b     (op_b),
   .res_vld  (res_vld),
   .res_prod (res_prod)
);

// File: tb/r4m_mult_bench.sv
module r4m_mult_bench;

   localparam int OPW = 16;
   localparam int PW  = 32;
   localparam int LAT = 9;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           op_vld = 1'b0;
   logic [OPW-1:0] op_a = '0;
   logic [OPW-1:0] op_b = '0;
   logic           res_vld;
   logic [PW-1:0]  res_prod;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   logic [PW-1:0] q_prod [$];
   int            q_cyc  [$];
   string         q_tag  [$];

   always #4 clk = ~clk;

   r4m_mult u_r4m_mult (
      .clk      (clk),
      .rst      (rst),
      .op_vld   (op_vld),
      .op_a     (op_a),
      .op_b     (op_b),
      .res_vld  (res_vld),
      .res_prod (res_prod)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input bit ok, input logic [PW-1:0] act,
                        input logic [PW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Scoreboard: compares every result against the queued reference
   always @(negedge clk) begin
      if (!rst && res_vld) begin
         if (q_prod.size() == 0) begin
            check("R5", 1'b0, PW'(res_vld), 0);
         end else begin
            logic [PW-1:0] e;
            int            c;
            string         t;
            e = q_prod.pop_front();
            c = q_cyc.pop_front();
            t = q_tag.pop_front();
            check(t, res_prod == e, res_prod, e);
            check("R2", (cyc - c) == LAT, PW'(cyc - c), PW'(LAT));
         end
      end
   end

   task automatic issue(input logic [OPW-1:0] a, input logic [OPW-1:0] b, input string tag);
      @(negedge clk);
      op_vld = 1'b1;
      op_a   = a;
      op_b   = b;
      q_prod.push_back(PW'(a) * PW'(b));
      q_cyc.push_back(cyc);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         op_vld = 1'b0;
         op_a   = 16'hDEAD;
         op_b   = 16'hBEEF;
      end
   endtask

   task automatic drain();
      idle(LAT + 3);
      check("R3", q_prod.size() == 0, PW'(q_prod.size()), 0);
   endtask

   task automatic t_reset_state();
      rst = 1'b1;
      idle(3);
      rst = 1'b0;
      for (int i = 0; i < LAT + 2; i++) begin
         @(negedge clk);
         check("R4", res_vld == 1'b0, PW'(res_vld), 0);
      end
   endtask

   task automatic t_extremes();
      issue(16'hFFFF, 16'hFFFF, "R6");
      issue(16'h0000, 16'hFFFF, "R6");
      issue(16'hFFFF, 16'h0000, "R6");
      issue(16'h0001, 16'h0001, "R1");
      issue(16'h0001, 16'hFFFF, "R1");
      drain();
   endtask

   task automatic t_digits();
      issue(16'hBEEF, 16'h5555, "R7");
      issue(16'hBEEF, 16'hAAAA, "R7");
      issue(16'hBEEF, 16'hFFFF, "R7");
      issue(16'hBEEF, 16'h0000, "R7");
      for (int k = 0; k < OPW / 2; k++) begin
         for (int d = 1; d < 4; d++) begin
            issue(16'hC3A5, OPW'(d << (2 * k)), "R7");
         end
      end
      drain();
   endtask

   task automatic t_back_to_back();
      for (int i = 0; i < 64; i++) begin
         issue(OPW'($urandom), OPW'($urandom), "R3");
      end
      drain();
   endtask

   task automatic t_bubbles();
      for (int i = 0; i < 40; i++) begin
         if (($urandom % 3) == 0) idle(1 + ($urandom % 3));
         issue(OPW'($urandom), OPW'($urandom), "R5");
      end
      drain();
   endtask

   task automatic t_reset_flush();
      for (int i = 0; i < 5; i++) issue(OPW'($urandom) | 16'h1, 16'h7777, "R4");
      @(negedge clk);
      rst    = 1'b1;
      op_vld = 1'b0;
      q_prod.delete();
      q_cyc.delete();
      q_tag.delete();
      idle(2);
      rst = 1'b0;
      for (int i = 0; i < LAT + 3; i++) begin
         @(negedge clk);
         check("R4", res_vld == 1'b0, PW'(res_vld), 0);
      end
      issue(16'h0003, 16'h0005, "R4");
      drain();
   endtask

   initial begin
      t_reset_state();
      t_extremes();
      t_digits();
      t_back_to_back();
      t_bubbles();
      t_reset_flush();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   always @(posedge clk) begin
      if (!done && cyc > 20000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule